// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Vector Logic

This block keeps the interrupt state of a two-channel serial controller. Each channel can raise three kinds of request: a byte has been received, the transmit buffer has been written, or a break condition has been seen. The block records which receive and transmit requests are pending and which are currently being serviced. From this state it builds a pending-interrupt byte and a status-modified vector byte that the host reads. It also drives one active-high interrupt line, which is the OR of the requests from both channels.

The host services interrupts with three kinds of action: acknowledging the received byte, a "clear transmit pending" command, and a "release highest in-service" command. These actions move the block between receive and transmit service. While a receive interrupt is in service, a transmit interrupt is held back. Whenever the state changes, the vector byte is rewritten using either the high-bit or the low-bit status encoding. All inputs are single-cycle strobes or static configuration bits. Every output changes on the clock edge that samples the strobe.

Channel A is index 0 of every per-channel port and channel B is index 1. The receive-mode field of channel A is `rx_mode[1:0]` and that of channel B is `rx_mode[3:2]`.

Top module: `dual_irq_vec`

## Requirements
- R1: After reset, `int_pend`, `int_vec` and `irq` are all zero, and the break status of both channels is clear.
- R2: A receive strobe marks the receive request pending and in service. It sets pending bit 5 for channel A or bit 2 for channel B. It writes the vector 0x30 (A) or 0x20 (B) when `stat_hi` is 1, and 0x0C (A) or 0x04 (B) when `stat_hi` is 0.
- R3: A transmit strobe always marks the transmit request pending. When the same channel has no receive request in service, it also marks the transmit request in service and writes the vector: channel A gives 0x10 (`stat_hi`=1) or 0x08 (`stat_hi`=0), and channel B gives 0x00. In that case it also sets pending bit 4 (A) or bit 1 (B), but only if that channel's `tx_ie` is 1. When a receive request is in service, neither the pending byte nor the vector changes.
- R4: `rx_ack` clears the channel's receive pending flag, its receive in-service flag and its receive pending bit. It writes the "no interrupt" vector: 0x60 when `stat_hi` is 1, 0x06 when it is 0. If a transmit request is still pending, it is then posted again as in R3.
- R5: A command with `cmd_op` = 3'b101 clears the channel's transmit pending flag, its transmit in-service flag and its transmit pending bit, and writes the "no interrupt" vector. If a receive request is still pending, it is then posted again as in R2.
- R6: A command with `cmd_op` = 3'b111 acts on the receive in-service flag when it is set: it clears that flag and posts any pending transmit request again as in R3. Otherwise it clears the transmit in-service flag and leaves the pending byte and the vector unchanged.
- R7: A command strobe with any other `cmd_op` value changes neither the pending byte, the vector nor `irq`.
- R8: `irq` is a register. A channel requests an interrupt when any of these holds: `tx_ie` is 1 and a transmit request is pending; the channel's receive-mode field is 2'b01 or 2'b10 and a receive request is pending; `brk_ie` is 1 and the break status is set. Receive-mode values 2'b00 and 2'b11 never request.
- R9: Bits 7, 6, 3 and 0 of `int_pend` are always zero.
- R10: Several actions on one channel in the same cycle take effect in this order: `rx_ack`, the clear-transmit command, the release-in-service command, the receive strobe, then the transmit strobe. When both channels write the vector in the same cycle, channel B's value is kept.
- R11: A break strobe sets the channel's break status, and the status stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_evt | input | 2 | Byte-received strobe per channel |
| tx_evt | input | 2 | Transmit-buffer-written strobe per channel |
| brk_evt | input | 2 | Break-detected strobe per channel |
| rx_ack | input | 2 | Host read of received data per channel |
| cmd_stb | input | 2 | Host command strobe per channel |
| cmd_op | input | 3 | Command code, shared by both channels |
| tx_ie | input | 2 | Transmit interrupt enable per channel |
| rx_mode | input | 4 | Receive interrupt mode, 2 bits per channel |
| brk_ie | input | 2 | Break interrupt enable per channel |
| stat_hi | input | 1 | Selects the high-bit vector encoding |
| irq | output | 1 | Combined interrupt request, active high |
| int_pend | output | 8 | Pending-interrupt byte |
| int_vec | output | 8 | Status-modified interrupt vector |

## Verification
A scripted sequence drives receive, transmit, acknowledge and command strobes on each channel, one at a time, under both vector encodings. This tells a correct channel-A vs channel-B bit placement apart from a swapped one, and a correct high vs low vector encoding apart from a wrong one. Patterns that put a transmit strobe behind a receive in service, release in-service state, and clear one request while the other is still pending separate correct blocking and re-posting from eager posting. Same-cycle strobes on one channel and on both channels expose wrong ordering and wrong vector priority. Directed steps vary the receive mode, the transmit enable and the break enable to show each interrupt source gating `irq` on its own.

// File: rtl/dual_irq_vec_pkg.sv
package dual_irq_vec_pkg;

   localparam int          CH_COUNT   = 2;
   localparam int          BYTE_W     = 8;
   localparam int          OP_W       = 3;
   localparam logic [OP_W-1:0] OP_CLR_TX  = 3'b101;
   localparam logic [OP_W-1:0] OP_CLR_IUS = 3'b111;

   typedef struct packed {
      logic rx_pnd;
      logic tx_pnd;
      logic rx_svc;
      logic tx_svc;
      logic rx_bit;
      logic tx_bit;
   } chan_st_t;

   typedef enum logic [1:0] {
      VK_NONE,
      VK_RX,
      VK_TX
   } vkind_t;

   function automatic logic [BYTE_W-1:0] vec_code(input vkind_t k,
                                                  input logic chan_b,
                                                  input logic hi);
      case (k)
         VK_RX:   vec_code = chan_b ? (hi ? 8'h20 : 8'h04) : (hi ? 8'h30 : 8'h0C);
         VK_TX:   vec_code = chan_b ? 8'h00 : (hi ? 8'h10 : 8'h08);
         default: vec_code = hi ? 8'h60 : 8'h06;
      endcase
   endfunction

   function automatic logic rx_mode_ok(input logic [1:0] m);
      return (m == 2'b01) || (m == 2'b10);
   endfunction

   function automatic chan_st_t post_rx(input chan_st_t s);
      post_rx        = s;
      post_rx.rx_pnd = 1'b1;
      post_rx.rx_svc = 1'b1;
      post_rx.rx_bit = 1'b1;
   endfunction

   function automatic chan_st_t post_tx(input chan_st_t s, input logic ie);
      post_tx        = s;
      post_tx.tx_pnd = 1'b1;
      if (!s.rx_svc) begin
         post_tx.tx_svc = 1'b1;
         if (ie) post_tx.tx_bit = 1'b1;
      end
   endfunction

endpackage

// File: rtl/div_chan.sv
module div_chan
   import dual_irq_vec_pkg::*;
#(
   parameter bit IS_B = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_evt,
   input  logic              tx_evt,
   input  logic              brk_evt,
   input  logic              rx_ack,
   input  logic              cmd_stb,
   input  logic [OP_W-1:0]   cmd_op,
   input  logic              tx_ie,
   input  logic [1:0]        rx_mode,
   input  logic              brk_ie,
   input  logic              stat_hi,
   output logic              pnd_rx,
   output logic              pnd_tx,
   output logic              vec_wr,
   output logic [BYTE_W-1:0] vec_val,
   output logic              req_nxt
);

   chan_st_t st_q, st_d;
   vkind_t   kind;
   logic     brk_q, brk_d;

   always_comb begin
      st_d   = st_q;
      kind   = VK_NONE;
      vec_wr = 1'b0;
      if (rx_ack) begin
         st_d.rx_pnd = 1'b0;
         st_d.rx_svc = 1'b0;
         st_d.rx_bit = 1'b0;
         vec_wr      = 1'b1;
         kind        = VK_NONE;
         if (st_d.tx_pnd) begin
            if (!st_d.rx_svc) kind = VK_TX;
            st_d = post_tx(st_d, tx_ie);
         end
      end
      if (cmd_stb && cmd_op == OP_CLR_TX) begin
         st_d.tx_pnd = 1'b0;
         st_d.tx_svc = 1'b0;
         st_d.tx_bit = 1'b0;
         vec_wr      = 1'b1;
         kind        = VK_NONE;
         if (st_d.rx_pnd) begin
            kind = VK_RX;
            st_d = post_rx(st_d);
         end
      end
      if (cmd_stb && cmd_op == OP_CLR_IUS) begin
         if (st_d.rx_svc) begin
            st_d.rx_svc = 1'b0;
            if (st_d.tx_pnd) begin
               vec_wr = 1'b1;
               kind   = VK_TX;
               st_d   = post_tx(st_d, tx_ie);
            end
         end else begin
            st_d.tx_svc = 1'b0;
         end
      end
      if (rx_evt) begin
         vec_wr = 1'b1;
         kind   = VK_RX;
         st_d   = post_rx(st_d);
      end
      if (tx_evt) begin
         if (!st_d.rx_svc) begin
            vec_wr = 1'b1;
            kind   = VK_TX;
         end
         st_d = post_tx(st_d, tx_ie);
      end
   end

   assign brk_d   = brk_q | brk_evt;
   assign vec_val = vec_code(kind, IS_B, stat_hi);
   assign req_nxt = (tx_ie & st_d.tx_pnd) |
                    (rx_mode_ok(rx_mode) & st_d.rx_pnd) |
                    (brk_ie & brk_d);
   assign pnd_rx  = st_q.rx_bit;
   assign pnd_tx  = st_q.tx_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= '0;
         brk_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         brk_q <= brk_d;
      end
   end

endmodule

// File: rtl/div_irq.sv
module div_irq #(
   parameter int NCH = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] req,
   output logic           irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |req;
   end

endmodule

// File: rtl/dual_irq_vec.sv
module dual_irq_vec
   import dual_irq_vec_pkg::*;
#(
   parameter int NUM_CH = CH_COUNT
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_CH-1:0]   rx_evt,
   input  logic [NUM_CH-1:0]   tx_evt,
   input  logic [NUM_CH-1:0]   brk_evt,
   input  logic [NUM_CH-1:0]   rx_ack,
   input  logic [NUM_CH-1:0]   cmd_stb,
   input  logic [OP_W-1:0]     cmd_op,
   input  logic [NUM_CH-1:0]   tx_ie,
   input  logic [2*NUM_CH-1:0] rx_mode,
   input  logic [NUM_CH-1:0]   brk_ie,
   input  logic                stat_hi,
   output logic                irq,
   output logic [BYTE_W-1:0]   int_pend,
   output logic [BYTE_W-1:0]   int_vec
);

   localparam int MODE_W = 2;

   if (NUM_CH != 2) begin : g_bad_nch
      $error("dual_irq_vec: NUM_CH must be 2");
   end
   if (BYTE_W != 8) begin : g_bad_byte
      $error("dual_irq_vec: register bytes must be 8 bits");
   end

   logic [NUM_CH-1:0] pnd_rx, pnd_tx, vec_wr, req_nxt;
   logic [BYTE_W-1:0] vec_val [NUM_CH];
   logic [BYTE_W-1:0] vec_q, vec_d;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      div_chan #(.IS_B(g == 1)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .rx_evt  (rx_evt[g]),
         .tx_evt  (tx_evt[g]),
         .brk_evt (brk_evt[g]),
         .rx_ack  (rx_ack[g]),
         .cmd_stb (cmd_stb[g]),
         .cmd_op  (cmd_op),
         .tx_ie   (tx_ie[g]),
         .rx_mode (rx_mode[g*MODE_W +: MODE_W]),
         .brk_ie  (brk_ie[g]),
         .stat_hi (stat_hi),
         .pnd_rx  (pnd_rx[g]),
         .pnd_tx  (pnd_tx[g]),
         .vec_wr  (vec_wr[g]),
         .vec_val (vec_val[g]),
         .req_nxt (req_nxt[g])
      );
   end

   // the highest-numbered channel writing this cycle owns the vector
   always_comb begin
      vec_d = vec_q;
      for (int i = 0; i < NUM_CH; i++) begin
         if (vec_wr[i]) vec_d = vec_val[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vec_q <= '0;
      else        vec_q <= vec_d;
   end

   div_irq #(.NCH(NUM_CH)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_nxt),
      .irq   (irq)
   );

   assign int_vec  = vec_q;
   assign int_pend = {2'b00, pnd_rx[0], pnd_tx[0], 1'b0, pnd_rx[1], pnd_tx[1], 1'b0};

endmodule

// File: rtl/dual_irq_vec_sva.sv
module dual_irq_vec_sva (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] rx_evt,
   input logic [1:0] tx_evt,
   input logic [1:0] brk_evt,
   input logic [1:0] rx_ack,
   input logic [1:0] cmd_stb,
   input logic [2:0] cmd_op,
   input logic [1:0] brk_ie,
   input logic       stat_hi,
   input logic       irq,
   input logic [7:0] int_pend,
   input logic [7:0] int_vec
);

   // R2: a lone channel-A receive strobe posts bit 5 and the A receive vector
   p_rx_post_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_evt == 2'b01 && tx_evt == 2'b00 && rx_ack == 2'b00 && cmd_stb == 2'b00)
      |=> (int_pend[5] && int_vec == ($past(stat_hi) ? 8'h30 : 8'h0C)));

   // R4: acknowledging channel B data drops its receive pending bit
   p_rx_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ack == 2'b10 && rx_evt == 2'b00) |=> !int_pend[2]);

   // R5: clearing channel A transmit drops pending bit 4
   p_clr_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb == 2'b01 && cmd_op == 3'b101 && tx_evt == 2'b00) |=> !int_pend[4]);

   // R9: unused pending bits stay low
   p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (int_pend & 8'hC9) == 8'h00);

   // R11: an enabled break raises the interrupt line on the next edge
   p_brk_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ((brk_evt & brk_ie) != 2'b00) |=> irq);

endmodule

bind dual_irq_vec dual_irq_vec_sva u_sva (.*);

// File: tb/test_dual_irq_vec.sv
module test_dual_irq_vec;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] rx_evt = '0, tx_evt = '0, brk_evt = '0, rx_ack = '0, cmd_stb = '0;
   logic [2:0] cmd_op = '0;
   logic [1:0] tx_ie = 2'b11, brk_ie = 2'b00;
   logic [3:0] rx_mode = 4'b1001;
   logic       stat_hi = 1'b0;
   logic       irq;
   logic [7:0] int_pend, int_vec;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   dual_irq_vec i_dual_irq_vec (
      .clk(clk), .rst_n(rst_n), .rx_evt(rx_evt), .tx_evt(tx_evt), .brk_evt(brk_evt),
      .rx_ack(rx_ack), .cmd_stb(cmd_stb), .cmd_op(cmd_op), .tx_ie(tx_ie),
      .rx_mode(rx_mode), .brk_ie(brk_ie), .stat_hi(stat_hi),
      .irq(irq), .int_pend(int_pend), .int_vec(int_vec)
   );

   typedef struct packed {
      logic [1:0] rx;
      logic [1:0] tx;
      logic [1:0] ack;
      logic [1:0] stb;
      logic [2:0] op;
      logic       hi;
      logic [7:0] pend;
      logic [7:0] vec;
      logic       irq;
   } row_t;

   localparam int NROW = 18;
   localparam row_t TBL [NROW] = '{
      '{2'b01, 2'b00, 2'b00, 2'b00, 3'b000, 1'b0, 8'h20, 8'h0C, 1'b1},
      '{2'b00, 2'b01, 2'b00, 2'b00, 3'b000, 1'b0, 8'h20, 8'h0C, 1'b1},
      '{2'b00, 2'b00, 2'b01, 2'b00, 3'b000, 1'b0, 8'h10, 8'h08, 1'b1},
      '{2'b00, 2'b00, 2'b00, 2'b01, 3'b111, 1'b0, 8'h10, 8'h08, 1'b1},
      '{2'b00, 2'b00, 2'b00, 2'b01, 3'b101, 1'b0, 8'h00, 8'h06, 1'b0},
      '{2'b10, 2'b00, 2'b00, 2'b00, 3'b000, 1'b1, 8'h04, 8'h20, 1'b1},
      '{2'b00, 2'b10, 2'b00, 2'b00, 3'b000, 1'b1, 8'h04, 8'h20, 1'b1},
      '{2'b00, 2'b00, 2'b00, 2'b10, 3'b111, 1'b1, 8'h06, 8'h00, 1'b1},
      '{2'b00, 2'b00, 2'b00, 2'b10, 3'b011, 1'b1, 8'h06, 8'h00, 1'b1},
      '{2'b00, 2'b00, 2'b00, 2'b10, 3'b101, 1'b1, 8'h04, 8'h20, 1'b1},
      '{2'b00, 2'b00, 2'b10, 2'b00, 3'b000, 1'b1, 8'h00, 8'h60, 1'b0},
      '{2'b00, 2'b01, 2'b00, 2'b00, 3'b000, 1'b1, 8'h10, 8'h10, 1'b1},
      '{2'b11, 2'b00, 2'b00, 2'b00, 3'b000, 1'b1, 8'h34, 8'h20, 1'b1},
      '{2'b00, 2'b00, 2'b11, 2'b00, 3'b000, 1'b1, 8'h10, 8'h60, 1'b1},
      '{2'b00, 2'b00, 2'b00, 2'b01, 3'b101, 1'b1, 8'h00, 8'h60, 1'b0},
      '{2'b01, 2'b01, 2'b00, 2'b00, 3'b000, 1'b0, 8'h20, 8'h0C, 1'b1},
      '{2'b00, 2'b00, 2'b01, 2'b00, 3'b000, 1'b0, 8'h10, 8'h08, 1'b1},
      '{2'b00, 2'b00, 2'b00, 2'b01, 3'b101, 1'b0, 8'h00, 8'h06, 1'b0}
   };

   function automatic string row_tag(input int i);
      case (i)
         0, 5:           return "R2";
         1, 6, 11:       return "R3";
         2, 10, 16:      return "R4";
         4, 9, 14, 17:   return "R5";
         3, 7:           return "R6";
         8:              return "R7";
         default:        return "R10";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // strobes are applied just after a falling edge, sampled 2 ns past the rising edge
   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic idle_strobes();
      @(negedge clk);
      rx_evt = '0; tx_evt = '0; brk_evt = '0; rx_ack = '0; cmd_stb = '0; cmd_op = '0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 pend", int_pend, 8'h00);
      chk("R1 vec", int_vec, 8'h00);
      chk("R1 irq", {7'd0, irq}, 8'h00);
      rst_n = 1'b1;

      for (int i = 0; i < NROW; i++) begin
         @(negedge clk);
         rx_evt = TBL[i].rx; tx_evt = TBL[i].tx; rx_ack = TBL[i].ack;
         cmd_stb = TBL[i].stb; cmd_op = TBL[i].op; stat_hi = TBL[i].hi;
         step();
         chk($sformatf("%s row %0d pend", row_tag(i), i), int_pend, TBL[i].pend);
         chk($sformatf("%s row %0d vec", row_tag(i), i), int_vec, TBL[i].vec);
         chk($sformatf("%s row %0d irq", row_tag(i), i), {7'd0, irq}, {7'd0, TBL[i].irq});
         chk("R9 reserved bits", int_pend & 8'hC9, 8'h00);
         idle_strobes();
      end

      // R8: receive mode 11 gives no request
      stat_hi = 1'b0; rx_mode = 4'b1011; rx_evt = 2'b01;
      step();
      chk("R8 mode11 pend", int_pend, 8'h20);
      chk("R8 mode11 irq", {7'd0, irq}, 8'h00);
      idle_strobes();
      rx_mode = 4'b1000;
      step();
      chk("R8 mode00 irq", {7'd0, irq}, 8'h00);
      idle_strobes();
      rx_mode = 4'b1001;
      step();
      chk("R8 mode01 irq", {7'd0, irq}, 8'h01);
      idle_strobes();
      rx_ack = 2'b01;
      step();
      chk("R4 ack pend", int_pend, 8'h00);
      chk("R4 ack vec", int_vec, 8'h06);
      idle_strobes();

      // R3: transmit enable off keeps pending bit clear, vector still written
      tx_ie = 2'b00; tx_evt = 2'b10;
      step();
      chk("R3 no-ie pend", int_pend, 8'h00);
      chk("R3 no-ie vec", int_vec, 8'h00);
      chk("R8 no-ie irq", {7'd0, irq}, 8'h00);
      idle_strobes();
      tx_ie = 2'b11;
      step();
      chk("R8 tx enable irq", {7'd0, irq}, 8'h01);
      idle_strobes();
      cmd_stb = 2'b10; cmd_op = 3'b101;
      step();
      chk("R5 clear B vec", int_vec, 8'h06);
      chk("R5 clear B irq", {7'd0, irq}, 8'h00);
      idle_strobes();

      // R11: break gated by enable, then sticky
      brk_evt = 2'b01;
      step();
      chk("R11 brk masked irq", {7'd0, irq}, 8'h00);
      idle_strobes();
      brk_ie = 2'b01;
      step();
      chk("R11 brk enabled irq", {7'd0, irq}, 8'h01);
      repeat (3) @(posedge clk);
      #2;
      chk("R11 brk sticky irq", {7'd0, irq}, 8'h01);
      chk("R7 brk leaves pend", int_pend, 8'h00);

      // R1: reset clears break status
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      step();
      chk("R1 re-reset irq", {7'd0, irq}, 8'h00);
      chk("R1 re-reset vec", int_vec, 8'h00);
      chk("R1 re-reset pend", int_pend, 8'h00);

      finish_run();
   end

endmodule